// File: doc/BRIEF.md
# Auxiliary Sensor Burst Read Sequencer

This block runs one slot of an auxiliary sensor-bus master. On every sample tick an enabled slot asks a byte-level bus engine for one transaction. The transaction can first write a start register address, and it then reads a programmed number of bytes. Each byte that comes back is written into a shared external-data buffer. The write position is measured from a base entry index that arrives from outside the block.

Sensor data usually comes in two-byte words. With swapping on, the two bytes of each word are stored in reverse order. A configuration bit sets how the source addresses pair into words: either even-then-odd, or odd-then-even. Only pairs whose two bytes both fall inside the burst are reversed. A lone byte at the start or end of the burst keeps its position.

When the burst ends, the block pulses done and presents the next free buffer index. A following slot can chain its base index from that value.

Top module: `aux_read_seq`

## Requirements
- R1: After reset, busStart, bufWrEn and done are 0, and nextIndex is 0.
- R2: A sample tick while cfgEnable is 0 produces no bus start, no buffer write and no done pulse.
- R3: A sample tick with cfgEnable at 1 and a non-zero length raises busStart for exactly one cycle, in the cycle after the tick. From that cycle busAddr equals the latched start address and busLen equals the latched length.
- R4: busSkipRegWr equals the latched register-write-disable bit (1 means the engine skips the address write and only reads).
- R5: With swap off, the k-th received byte (k from 0) is written at index base+k. The write (bufWrEn, bufWrIdx, bufWrData) appears in the cycle after busByteValid is sampled.
- R6: With swap on and group bit 0, addresses 2n and 2n+1 form a word. When both are in the burst, the byte from 2n is stored one entry above the byte from 2n+1.
- R7: With swap on and group bit 1, addresses 2n+1 and 2n+2 form a word and are reversed the same way when both are in the burst.
- R8: With swap on, a leading byte that is the second of its word, or a trailing byte that is the first of its word, is stored at base+k. Example: start 1, length 4, group 0 gives offsets 0,2,1,3.
- R9: done is high for one cycle, in the same cycle as the write of the last byte. In that cycle nextIndex equals base+length, and it holds that value until the next done.
- R10: A length of 0 gives a done pulse one cycle after the tick, with no bus start and no buffer write, and nextIndex equal to base.
- R11: A sample tick that arrives during a burst is ignored: no new bus start, and the running burst keeps its configuration. A busByteValid pulse while idle causes no write.
- R12: Buffer indices and nextIndex wrap modulo 2^IDX_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | Sample-rate tick |
| cfgEnable | input | 1 | Slot enable |
| cfgSwap | input | 1 | Reverse complete two-byte words |
| cfgRegWrDis | input | 1 | Skip the register-address write |
| cfgGroupOdd | input | 1 | 0: pair (even,odd); 1: pair (odd,even) |
| cfgStartAddr | input | ADDR_W | First register address to read |
| cfgLength | input | LEN_W | Bytes to read |
| baseIndex | input | IDX_W | First free buffer entry |
| busStart | output | 1 | Transaction request pulse to the byte engine |
| busAddr | output | ADDR_W | Start address for the engine |
| busLen | output | LEN_W | Byte count for the engine |
| busSkipRegWr | output | 1 | Engine skips the address write |
| busByteValid | input | 1 | One pulse per received byte |
| busByteData | input | DATA_W | Received byte |
| bufWrEn | output | 1 | Buffer write enable |
| bufWrIdx | output | IDX_W | Buffer write index |
| bufWrData | output | DATA_W | Buffer write data |
| done | output | 1 | Burst complete pulse |
| nextIndex | output | IDX_W | Next free index (base + length) |

## Verification
Each result has a fixed latency. busStart is due one cycle after the tick is sampled. Each buffer write is due one cycle after its busByteValid is sampled, and done and nextIndex arrive with the last write. For a zero-length burst, done comes one cycle after the tick. The bench drives inputs on falling edges and samples outputs on the next falling edge, so every check reads the cycle where its result is due. The checks then confirm in the following cycle that the pulses have dropped. The expected offsets come from a word-membership model of address pairing, which is built differently from the parity logic in the design.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // latch configuration, clear byte count
    logic take;    // accept one received byte
    logic finish;  // burst complete this cycle
  } seqStrobe_t;
endpackage

// File: rtl/aux_seq_ctl.sv
module aux_seq_ctl
  import aux_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       cfgEnable,
  input  logic       zeroLen,
  input  logic       busByteValid,
  input  logic       lastByte,
  output seqStrobe_t strobe,
  output logic       busStart
);
  typedef enum logic {S_IDLE, S_RECV} seqState_t;
  seqState_t state, stateNext;

  logic kick;
  assign kick = (state == S_IDLE) && sampleTick && cfgEnable;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (kick) begin
          strobe.load = 1'b1;
          if (zeroLen) strobe.finish = 1'b1;
          else         stateNext     = S_RECV;
        end
      end
      S_RECV: begin
        if (busByteValid) begin
          strobe.take = 1'b1;
          if (lastByte) begin
            strobe.finish = 1'b1;
            stateNext     = S_IDLE;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      busStart <= 1'b0;
    end else begin
      state    <= stateNext;
      busStart <= kick && !zeroLen;
    end
  end

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    busStart |=> !busStart);
  // R2
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    busStart |-> $past(sampleTick && cfgEnable));
  // R11
  busy_tick_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RECV && sampleTick) |=> !busStart);
endmodule

// File: rtl/aux_seq_dp.sv
module aux_seq_dp
  import aux_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 4,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              busByteValid,
  input  logic              cfgSwap,
  input  logic              cfgRegWrDis,
  input  logic              cfgGroupOdd,
  input  logic [ADDR_W-1:0] cfgStartAddr,
  input  logic [LEN_W-1:0]  cfgLength,
  input  logic [IDX_W-1:0]  baseIndex,
  input  logic [DATA_W-1:0] busByteData,
  output logic              lastByte,
  output logic [ADDR_W-1:0] busAddr,
  output logic [LEN_W-1:0]  busLen,
  output logic              busSkipRegWr,
  output logic              bufWrEn,
  output logic [IDX_W-1:0]  bufWrIdx,
  output logic [DATA_W-1:0] bufWrData,
  output logic              done,
  output logic [IDX_W-1:0]  nextIndex
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W:0]   EXT_ONE = (LEN_W+1)'(1);

  logic [ADDR_W-1:0] startQ;
  logic [LEN_W-1:0]  lenQ, countQ;
  logic [IDX_W-1:0]  baseQ;
  logic              swapQ, groupQ, skipQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      lenQ   <= '0;
      baseQ  <= '0;
      swapQ  <= 1'b0;
      groupQ <= 1'b0;
      skipQ  <= 1'b0;
      countQ <= '0;
    end else if (strobe.load) begin
      startQ <= cfgStartAddr;
      lenQ   <= cfgLength;
      baseQ  <= baseIndex;
      swapQ  <= cfgSwap;
      groupQ <= cfgGroupOdd;
      skipQ  <= cfgRegWrDis;
      countQ <= '0;
    end else if (strobe.take) begin
      countQ <= countQ + LEN_ONE;
    end
  end

  assign busAddr      = startQ;
  assign busLen       = lenQ;
  assign busSkipRegWr = skipQ;
  assign lastByte     = (countQ == (lenQ - LEN_ONE));

  // Word position of the current byte: address LSB against group bit
  logic addrLsb, wordHead, hasNext, hasPrev;
  logic [LEN_W:0] cntPlus;
  assign addrLsb  = startQ[0] ^ countQ[0];
  assign wordHead = (addrLsb == groupQ);
  assign cntPlus  = {1'b0, countQ} + EXT_ONE;
  assign hasNext  = cntPlus < {1'b0, lenQ};
  assign hasPrev  = (countQ != '0);

  logic [LEN_W-1:0] offset;
  always_comb begin
    offset = countQ;
    if (swapQ) begin
      if (wordHead && hasNext)       offset = countQ + LEN_ONE;
      else if (!wordHead && hasPrev) offset = countQ - LEN_ONE;
    end
  end

  logic [IDX_W-1:0] finBase;
  logic [LEN_W-1:0] finLen;
  assign finBase = strobe.load ? baseIndex : baseQ;
  assign finLen  = strobe.load ? cfgLength : lenQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufWrEn   <= 1'b0;
      bufWrIdx  <= '0;
      bufWrData <= '0;
      done      <= 1'b0;
      nextIndex <= '0;
    end else begin
      bufWrEn <= strobe.take;
      done    <= strobe.finish;
      if (strobe.take) begin
        bufWrIdx  <= baseQ + IDX_W'(offset);
        bufWrData <= busByteData;
      end
      if (strobe.finish) nextIndex <= finBase + IDX_W'(finLen);
    end
  end

  logic [IDX_W-1:0] relIdx;
  assign relIdx = bufWrIdx - baseQ;

  // R5
  write_after_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> $past(busByteValid));
  // R8
  write_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (relIdx < IDX_W'(lenQ)));
  // R9
  done_with_last_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && lenQ != '0) |-> bufWrEn);
  // R10
  zero_len_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && lenQ == '0) |-> !bufWrEn);
endmodule

// File: rtl/aux_read_seq.sv
module aux_read_seq
  import aux_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 4,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              cfgEnable,
  input  logic              cfgSwap,
  input  logic              cfgRegWrDis,
  input  logic              cfgGroupOdd,
  input  logic [ADDR_W-1:0] cfgStartAddr,
  input  logic [LEN_W-1:0]  cfgLength,
  input  logic [IDX_W-1:0]  baseIndex,
  output logic              busStart,
  output logic [ADDR_W-1:0] busAddr,
  output logic [LEN_W-1:0]  busLen,
  output logic              busSkipRegWr,
  input  logic              busByteValid,
  input  logic [DATA_W-1:0] busByteData,
  output logic              bufWrEn,
  output logic [IDX_W-1:0]  bufWrIdx,
  output logic [DATA_W-1:0] bufWrData,
  output logic              done,
  output logic [IDX_W-1:0]  nextIndex
);
  seqStrobe_t strobe;
  logic       lastByte;
  logic       zeroLen;
  assign zeroLen = (cfgLength == '0);

  aux_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .cfgEnable(cfgEnable),
    .zeroLen(zeroLen), .busByteValid(busByteValid), .lastByte(lastByte),
    .strobe(strobe), .busStart(busStart)
  );

  aux_seq_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busByteValid(busByteValid),
    .cfgSwap(cfgSwap), .cfgRegWrDis(cfgRegWrDis), .cfgGroupOdd(cfgGroupOdd),
    .cfgStartAddr(cfgStartAddr), .cfgLength(cfgLength), .baseIndex(baseIndex),
    .busByteData(busByteData), .lastByte(lastByte), .busAddr(busAddr),
    .busLen(busLen), .busSkipRegWr(busSkipRegWr), .bufWrEn(bufWrEn),
    .bufWrIdx(bufWrIdx), .bufWrData(bufWrData), .done(done), .nextIndex(nextIndex)
  );
endmodule

// File: tb/aux_read_seq_tb.sv
`timescale 1ns/1ps
module aux_read_seq_tb;
  localparam int IDX_W = 5;
  localparam int IDX_MOD = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0, cfgEnable = 1'b0, cfgSwap = 1'b0;
  logic cfgRegWrDis = 1'b0, cfgGroupOdd = 1'b0;
  logic [7:0] cfgStartAddr = '0;
  logic [3:0] cfgLength = '0;
  logic [IDX_W-1:0] baseIndex = '0;
  logic busByteValid = 1'b0;
  logic [7:0] busByteData = '0;
  logic busStart, busSkipRegWr, bufWrEn, done;
  logic [7:0] busAddr, bufWrData;
  logic [3:0] busLen;
  logic [IDX_W-1:0] bufWrIdx, nextIndex;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  aux_read_seq u_dut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .cfgEnable(cfgEnable),
    .cfgSwap(cfgSwap), .cfgRegWrDis(cfgRegWrDis), .cfgGroupOdd(cfgGroupOdd),
    .cfgStartAddr(cfgStartAddr), .cfgLength(cfgLength), .baseIndex(baseIndex),
    .busStart(busStart), .busAddr(busAddr), .busLen(busLen),
    .busSkipRegWr(busSkipRegWr), .busByteValid(busByteValid),
    .busByteData(busByteData), .bufWrEn(bufWrEn), .bufWrIdx(bufWrIdx),
    .bufWrData(bufWrData), .done(done), .nextIndex(nextIndex)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Offset model: bytes pair when they share a word id
  function automatic int expOff(int start, int k, int len, bit grp, bit swp);
    int a, w;
    if (!swp) return k;
    a = start + k;
    w = (a + grp) / 2;
    if (k + 1 < len && ((a + 1 + grp) / 2) == w) return k + 1;
    if (k > 0 && ((a - 1 + grp) / 2) == w) return k - 1;
    return k;
  endfunction

  task automatic runBurst(input string req, input int start, input int len, input bit swp,
                          input bit grp, input bit skip, input int base, input bit poke);
    cfgStartAddr = 8'(start); cfgLength = 4'(len); cfgSwap = swp;
    cfgGroupOdd = grp; cfgRegWrDis = skip; baseIndex = IDX_W'(base);
    cfgEnable = 1'b1; sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
    check("R3", {req, " busStart"}, busStart, 1);
    check("R3", {req, " busAddr"}, busAddr, start);
    check("R3", {req, " busLen"}, busLen, len);
    check("R4", {req, " busSkipRegWr"}, busSkipRegWr, skip);
    @(negedge clk);
    check("R3", {req, " busStart drop"}, busStart, 0);
    for (int k = 0; k < len; k++) begin
      busByteValid = 1'b1;
      busByteData = 8'((8'h5A ^ (start + k)));
      if (poke && k == 0) begin
        sampleTick = 1'b1;
        cfgStartAddr = 8'hEE; cfgLength = 4'd9; baseIndex = '0;
      end
      @(negedge clk);
      busByteValid = 1'b0;
      if (poke && k == 0) begin
        sampleTick = 1'b0;
        check("R11", {req, " busy tick no start"}, busStart, 0);
      end
      check(req, "write enable", bufWrEn, 1);
      check(req, "write index", bufWrIdx, (base + expOff(start, k, len, grp, swp)) % IDX_MOD);
      check(req, "write data", bufWrData, (8'h5A ^ (start + k)) & 8'hFF);
      check("R9", {req, " done timing"}, done, (k == len - 1) ? 1 : 0);
      if (k == len - 1)
        check("R9", {req, " nextIndex"}, nextIndex, (base + len) % IDX_MOD);
      if (poke) check("R11", {req, " addr kept"}, busAddr, start);
    end
    @(negedge clk);
    check("R9", {req, " done drop"}, done, 0);
    check("R9", {req, " nextIndex held"}, nextIndex, (base + len) % IDX_MOD);
    check(req, "no extra write", bufWrEn, 0);
  endtask

  task automatic t_reset();
    check("R1", "busStart", busStart, 0);
    check("R1", "bufWrEn", bufWrEn, 0);
    check("R1", "done", done, 0);
    check("R1", "nextIndex", nextIndex, 0);
  endtask

  task automatic t_disabled();
    cfgEnable = 1'b0; cfgLength = 4'd3; sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check("R2", "busStart", busStart, 0);
      check("R2", "done", done, 0);
      check("R2", "bufWrEn", bufWrEn, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_zeroLen();
    cfgEnable = 1'b1; cfgLength = 4'd0; baseIndex = 5'd9; sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
    check("R10", "done", done, 1);
    check("R10", "busStart", busStart, 0);
    check("R10", "bufWrEn", bufWrEn, 0);
    check("R10", "nextIndex", nextIndex, 9);
    @(negedge clk);
    check("R10", "done drop", done, 0);
    check("R10", "busStart later", busStart, 0);
  endtask

  task automatic t_strayValid();
    busByteValid = 1'b1; busByteData = 8'hC3;
    @(negedge clk);
    busByteValid = 1'b0;
    check("R11", "idle valid no write", bufWrEn, 0);
    check("R11", "idle valid no done", done, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    runBurst("R5", 8'h10, 4, 0, 0, 0, 0, 0);
    runBurst("R6", 8'h20, 6, 1, 0, 1, 3, 0);
    runBurst("R7", 8'h21, 5, 1, 1, 0, 7, 0);
    runBurst("R8", 8'h01, 4, 1, 0, 0, 0, 0);
    runBurst("R8", 8'h30, 3, 1, 1, 0, 12, 0);
    t_zeroLen();
    t_strayValid();
    runBurst("R11", 8'h40, 3, 0, 0, 0, 2, 1);
    runBurst("R12", 8'h50, 4, 0, 0, 0, 30, 0);
    runBurst("R12", 8'h51, 4, 1, 1, 0, 31, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule